// File: doc/BRIEF.md
# Firmware Hub Write-Cycle Target

This block is the target side of a 4-bit multiplexed firmware-hub bus, restricted to single-byte memory writes. It watches an active-low frame strobe and the shared nibble bus. It recognises a write frame and compares the ID select field against its strap inputs. It then collects a 28-bit address and one data byte from the nibble stream.

When a frame is accepted, the block takes the bus after the host's turnaround. It drives a ready sync nibble, then its own turnaround nibble, and then releases the bus. A one-clock write strobe is raised together with the sync and presents the captured address and byte to the memory side. The tri-state pad is modelled as a separate output nibble and output enable.

A frame whose ID does not match the straps, or whose size field is not one byte, is dropped without any bus drive or strobe. Pulling the frame strobe low at any point aborts the frame in progress and restarts decoding.

Top module: `fwh_write_target`

## Requirements
- R1: While reset is asserted and after its release, the bus enable and the write strobe are low until a frame is accepted.
- R2: A frame starts only on a clock where the frame strobe is low and the bus carries 1110b. With several such clocks in a row, the last one (the clock before the strobe returns high) begins the frame. A 1110b nibble seen with the strobe high is ignored.
- R3: The clock after the start carries the ID select. If it differs from the 4-bit straps, the frame is ignored: no bus enable and no write strobe.
- R4: The next seven clocks carry the address, most significant nibble first. The first nibble lands in bits 27:24 of the write address and the seventh in bits 3:0.
- R5: The clock after the address carries the size. Any value other than 0000b makes the block ignore the frame.
- R6: The next two clocks carry the data byte, low nibble (bits 3:0) first and then high nibble (bits 7:4).
- R7: The block does not enable its bus drivers during clocks 1 to 14 of a frame, which includes the two host turnaround clocks 13 and 14.
- R8: On clock 15 of an accepted frame the block drives 0000b. The write strobe is high for that one clock only, with the address and data valid beside it.
- R9: On clock 16 the block drives 1111b. On clock 17 its drivers are disabled.
- R10: A low frame strobe during a frame aborts it. From the next clock the drivers are off and no strobe is raised, and decoding follows the start rule of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all fields sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame strobe |
| bus_in | input | 4 | Nibble bus as seen at the pad input |
| id_strap | input | 4 | Device ID straps |
| bus_out | output | 4 | Nibble driven onto the bus when enabled |
| bus_oe | output | 1 | Bus driver enable |
| wr_valid | output | 1 | One-clock write strobe to the memory side |
| wr_addr | output | 28 | Captured write address |
| wr_data | output | 8 | Captured write data byte |

## Verification
The hardest situation to reach is an abort that lands while the block itself is driving the bus, on the sync clock or its own turnaround clock. There the frame strobe and the block's driver enable are active at once, and the next frame must still decode cleanly. The bench reaches it by cutting frames short at chosen clock numbers, including 15 and 16, and then starting a full frame straight away. Other cases use chains of start clocks, some with non-start nibbles mixed in. The ID matching is covered by a full sweep of strap against ID select, and every bad size value is swept.

// File: rtl/fwh_pkg.sv
package fwh_pkg;
  localparam int NIB_W     = 4;
  localparam int ADDR_NIBS = 7;
  localparam int ADDR_W    = NIB_W * ADDR_NIBS;
  localparam int BYTE_W    = 2 * NIB_W;

  localparam logic [NIB_W-1:0] START_NIB = 4'b1110;
  localparam logic [NIB_W-1:0] SIZE_ONE  = 4'b0000;
  localparam logic [NIB_W-1:0] SYNC_RDY  = 4'b0000;
  localparam logic [NIB_W-1:0] TURN_NIB  = 4'b1111;

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_ADDR, S_SIZE, S_DLO, S_DHI,
    S_HTAR0, S_HTAR1, S_SYNC, S_DTAR
  } fwh_state_e;

  function automatic logic [ADDR_W-1:0] addr_push(
    input logic [ADDR_W-1:0] acc, input logic [NIB_W-1:0] nib);
    return {acc[ADDR_W-NIB_W-1:0], nib};
  endfunction

  function automatic logic [BYTE_W-1:0] byte_join(
    input logic [NIB_W-1:0] lo, input logic [NIB_W-1:0] hi);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/fwh_start_detect.sv
module fwh_start_detect
  import fwh_pkg::*;
(
  input  logic             frame_n,
  input  logic [NIB_W-1:0] bus_in,
  output logic             start_hit,
  output logic             frame_cut
);
  assign start_hit = !frame_n && (bus_in == START_NIB);
  assign frame_cut = !frame_n;
endmodule

// File: rtl/fwh_capture.sv
module fwh_capture
  import fwh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  nib,
  input  logic              addr_en,
  input  logic              lo_en,
  input  logic              hi_en,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BYTE_W-1:0] data_q
);
  logic [NIB_W-1:0] lo_q;
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (addr_en) addr_q <= addr_push(addr_q, nib);
      if (lo_en)   lo_q   <= nib;
      if (hi_en)   hi_q   <= nib;
    end
  end

  assign data_q = byte_join(lo_q, hi_q);
endmodule

// File: rtl/fwh_write_target.sv
module fwh_write_target
  import fwh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [NIB_W-1:0]  bus_in,
  input  logic [NIB_W-1:0]  id_strap,
  output logic [NIB_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(ADDR_NIBS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

  fwh_state_e     st, st_nxt;
  logic [CNT_W-1:0] cnt;

  logic start_hit, frame_cut;
  logic in_id, id_match, in_size, size_ok, addr_last, st_is_idle;

  fwh_start_detect u_start (
    .frame_n   (frame_n),
    .bus_in    (bus_in),
    .start_hit (start_hit),
    .frame_cut (frame_cut)
  );

  assign in_id      = (st == S_ID);
  assign id_match   = (bus_in == id_strap);
  assign in_size    = (st == S_SIZE);
  assign size_ok    = (bus_in == SIZE_ONE);
  assign addr_last  = (cnt == CNT_LAST);
  assign st_is_idle = (st == S_IDLE);

  always_comb begin
    st_nxt = st;
    if (frame_cut) begin
      st_nxt = start_hit ? S_ID : S_IDLE;
    end else begin
      case (st)
        S_IDLE:  st_nxt = S_IDLE;
        S_ID:    st_nxt = id_match ? S_ADDR : S_IDLE;
        S_ADDR:  st_nxt = addr_last ? S_SIZE : S_ADDR;
        S_SIZE:  st_nxt = size_ok ? S_DLO : S_IDLE;
        S_DLO:   st_nxt = S_DHI;
        S_DHI:   st_nxt = S_HTAR0;
        S_HTAR0: st_nxt = S_HTAR1;
        S_HTAR1: st_nxt = S_SYNC;
        S_SYNC:  st_nxt = S_DTAR;
        S_DTAR:  st_nxt = S_IDLE;
        default: st_nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st <= st_nxt;
      if (st == S_ADDR && !frame_cut) cnt <= cnt + 1'b1;
      else                            cnt <= '0;
    end
  end

  fwh_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .nib     (bus_in),
    .addr_en (st == S_ADDR && !frame_cut),
    .lo_en   (st == S_DLO && !frame_cut),
    .hi_en   (st == S_DHI && !frame_cut),
    .addr_q  (wr_addr),
    .data_q  (wr_data)
  );

  assign bus_oe   = (st == S_SYNC) || (st == S_DTAR);
  assign bus_out  = (st == S_SYNC) ? SYNC_RDY : TURN_NIB;
  assign wr_valid = (st == S_SYNC);
endmodule

// File: rtl/fwh_write_target_chk.sv
module fwh_write_target_chk
  import fwh_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             frame_n,
  input logic [NIB_W-1:0] bus_out,
  input logic             bus_oe,
  input logic             wr_valid,
  input logic             in_id,
  input logic             id_match,
  input logic             in_size,
  input logic             size_ok,
  input logic             st_is_idle
);
  p_sync_nibble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (bus_oe && bus_out == SYNC_RDY));

  p_turn_after_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && frame_n) |=> (bus_oe && bus_out == TURN_NIB && !wr_valid));

  p_float_after_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !wr_valid) |=> !bus_oe);

  p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (!bus_oe && !wr_valid));

  p_id_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_id && !id_match && frame_n) |=> st_is_idle);

  p_size_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_size && !size_ok && frame_n) |=> st_is_idle);
endmodule

bind fwh_write_target fwh_write_target_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .bus_out    (bus_out),
  .bus_oe     (bus_oe),
  .wr_valid   (wr_valid),
  .in_id      (in_id),
  .id_match   (id_match),
  .in_size    (in_size),
  .size_ok    (size_ok),
  .st_is_idle (st_is_idle)
);

// File: tb/test_fwh_write_target.sv
module test_fwh_write_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  id_strap = 4'h0;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic        wr_valid;
  logic [27:0] wr_addr;
  logic [7:0]  wr_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fwh_write_target i_fwh_write_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
    .id_strap(id_strap), .bus_out(bus_out), .bus_oe(bus_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {oe, out, valid} expected while the block is silent
  task automatic expect_quiet(input string req);
    chk(!bus_oe && !wr_valid, req, {bus_oe, bus_out, wr_valid}, 6'h1E);
  endtask

  // one clock of host stimulus, outputs checked first at the same negedge
  task automatic host_clk(input logic fr, input logic [3:0] nib, input string req);
    @(negedge clk);
    expect_quiet(req);
    frame_n = fr;
    bus_in  = nib;
  endtask

  // Full 17-clock write frame. abort_at>0 replaces that clock by frame low 0000b.
  task automatic run_frame(input logic [3:0] id, input logic [27:0] addr,
                           input logic [3:0] size, input logic [7:0] data,
                           input bit ack, input int abort_at, input string rej_req);
    for (int c = 1; c <= 17; c++) begin
      logic [3:0] nib;
      logic       fr;
      @(negedge clk);
      if (ack && c == 15) begin
        chk(bus_oe && bus_out == 4'h0 && wr_valid, "R8",
            {bus_oe, bus_out, wr_valid}, {1'b1, 4'h0, 1'b1});
        chk(wr_addr == addr, "R4", wr_addr, addr);
        chk(wr_data == data, "R6", wr_data, data);
      end else if (ack && c == 16) begin
        chk(bus_oe && bus_out == 4'hF && !wr_valid, "R9",
            {bus_oe, bus_out, wr_valid}, {1'b1, 4'hF, 1'b0});
      end else if (ack && c == 17) begin
        expect_quiet("R9");
      end else begin
        expect_quiet(ack ? "R7" : rej_req);
      end
      fr = (c == 1) ? 1'b0 : 1'b1;
      case (c)
        1:  nib = 4'hE;
        2:  nib = id;
        10: nib = size;
        11: nib = data[3:0];
        12: nib = data[7:4];
        default: nib = (c >= 3 && c <= 9) ? addr[(9 - c) * 4 +: 4] : 4'hF;
      endcase
      if (abort_at == c) begin
        frame_n = 1'b0;
        bus_in  = 4'h0;
        return;
      end
      frame_n = fr;
      bus_in  = nib;
    end
  endtask

  function automatic logic [27:0] mk_addr(input int s);
    logic [31:0] v = 32'(s) * 32'h9E3779B1 + 32'h0123_4567;
    return v[27:0];
  endfunction

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    expect_quiet("R1");
    rst_n = 1'b1;
    repeat (2) host_clk(1'b1, 4'hF, "R1");

    // R3 + R4 + R6: full sweep of strap against ID select
    for (int s = 0; s < 16; s++) begin
      id_strap = 4'(s);
      for (int i = 0; i < 16; i++) begin
        run_frame(4'(i), mk_addr(s * 16 + i), 4'h0, 8'(s * 16 + i * 7 + 3),
                  (i == s), 0, "R3");
      end
    end

    // R5: every unsupported size is ignored
    id_strap = 4'h9;
    for (int z = 1; z < 16; z++)
      run_frame(4'h9, mk_addr(z + 500), 4'(z), 8'hA5, 1'b0, 0, "R5");
    run_frame(4'h9, 28'h0000001, 4'h0, 8'h01, 1'b1, 0, "R5");

    // R4/R6 edge patterns
    run_frame(4'h9, 28'hFFFFFFF, 4'h0, 8'hFF, 1'b1, 0, "R4");
    run_frame(4'h9, 28'h8000000, 4'h0, 8'h80, 1'b1, 0, "R6");
    run_frame(4'h9, 28'h1234567, 4'h0, 8'h0F, 1'b1, 0, "R6");

    // R2: START with strobe high is ignored
    host_clk(1'b1, 4'hE, "R2");
    for (int c = 0; c < 16; c++) host_clk(1'b1, (c == 0) ? 4'h9 : 4'h0, "R2");

    // R2: last of several starts counts; junk nibble before a start
    host_clk(1'b0, 4'hE, "R2");
    host_clk(1'b0, 4'hE, "R2");
    run_frame(4'h9, 28'h0ABCDEF, 4'h0, 8'h3C, 1'b1, 0, "R2");
    host_clk(1'b0, 4'hE, "R2");
    host_clk(1'b0, 4'h5, "R2");
    run_frame(4'h9, 28'h7654321, 4'h0, 8'hC3, 1'b1, 0, "R2");

    // R10: abort at various clocks, then a clean frame
    for (int a = 2; a <= 16; a++) begin
      run_frame(4'h9, mk_addr(a + 900), 4'h0, 8'(a), (a >= 15), a, "R10");
      host_clk(1'b1, 4'hF, "R10");
      run_frame(4'h9, mk_addr(a + 950), 4'h0, 8'(a + 100), 1'b1, 0, "R10");
    end

    // R10: abort by a new start mid-frame resynchronises on that start
    run_frame(4'h9, 28'h1111111, 4'h0, 8'h11, 1'b0, 6, "R10");
    bus_in = 4'hE;
    host_clk(1'b1, 4'h9, "R10");
    for (int c = 3; c <= 9; c++) host_clk(1'b1, 4'(c), "R10");
    host_clk(1'b1, 4'h0, "R10");
    host_clk(1'b1, 4'hD, "R10");
    host_clk(1'b1, 4'hB, "R10");
    host_clk(1'b1, 4'hF, "R10");
    host_clk(1'b1, 4'hF, "R10");
    @(negedge clk);
    chk(bus_oe && bus_out == 4'h0 && wr_valid, "R10",
        {bus_oe, bus_out, wr_valid}, {1'b1, 4'h0, 1'b1});
    chk(wr_addr == 28'h3456789 && wr_data == 8'hBD, "R10",
        {wr_addr[23:0], wr_data}, {24'h456789, 8'hBD});
    @(negedge clk);
    @(negedge clk);
    expect_quiet("R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule